// File: doc/BRIEF.md
# Direct-Mapped Data Cache Tag and Hit Unit

This block keeps the tag store and decides hit or miss for a direct-mapped data cache. The cache sits behind a 32-bit byte address. An incoming address is first tested against one cacheable window. The window is a naturally aligned power-of-two region, given by a base and a high bound. Addresses outside the window are reported as non-cacheable and never reach the tag store.

For an address inside the window, the unit splits it into a tag, a line index and a word select. It then reads one line entry. Each entry holds a tag, a line-valid bit and one valid bit per word of the line, so a line can be filled one word at a time. Lookups are registered and answer one clock after the request. A fill port writes the tag and word-valid bits as words arrive. An invalidate input starts a sweep that clears one line per clock. The same sweep runs after reset.

The tag width is not a free choice. It is log2 of the window size minus log2 of the cache size, so the tag and the cache field together cover exactly the cacheable window. No address bit above the window is stored.

Top module: `dct_tag_unit`

## Requirements
- R1: An address A is cacheable only when WIN_BASE <= A <= WIN_HIGH. A lookup of any other address returns result code 2'b00 (non-cacheable), and a fill to such an address changes no entry.
- R2: With window size 2^W, cache size 2^C and 2^O bytes per line (O = log2(LINE_WORDS)+2), the fields are: tag = A[W-1:C], line index = A[C-1:O], word select = A[O-1:2]. A[1:0] has no effect on a lookup or a fill.
- R3: A cacheable lookup returns 2'b01 (hit), with lk_hit high, when the line is valid, its stored tag equals the address tag and the valid bit of the addressed word is set.
- R4: A cacheable lookup to a valid line with a matching tag but a clear word-valid bit returns 2'b10 (word miss).
- R5: A cacheable lookup to an invalid line, or to a line whose tag differs, returns 2'b11 (line miss).
- R6: A cacheable fill to an invalid line, or to a line with a different tag, does three things: it stores the new tag, sets the line-valid bit, and leaves only the filled word valid.
- R7: A cacheable fill to a valid line with a matching tag sets that word's valid bit and keeps the line's other word-valid bits.
- R8: lk_valid and lk_result appear exactly one clock after lk_req is sampled high. A fill in the same cycle as a lookup is not visible to that lookup, but it is visible to the next one.
- R9: When inval_req is sampled high while the unit is idle, busy rises for exactly ENTRIES clocks. During those clocks line-valid bits are cleared one per clock in ascending index order. While busy is high, cacheable lookups return line miss, and both fills and further inval_req are ignored.
- R10: busy is high while rst_n is low. After rst_n is released, the unit runs the same ENTRIES-clock sweep. lk_valid is low during reset.
- R11: The configuration is rejected at start-up when any of these holds:
  - CACHE_BYTES is not a power of two from 64 to 65536;
  - LINE_WORDS is not 4, 8 or 16;
  - the cache holds fewer than two lines;
  - the window is not an aligned power of two;
  - the window is not larger than the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Lookup byte address |
| lk_valid | output | 1 | Lookup result valid, one clock after lk_req |
| lk_result | output | 2 | 00 non-cacheable, 01 hit, 10 word miss, 11 line miss |
| lk_hit | output | 1 | Result valid and a hit |
| fill_en | input | 1 | Mark one word valid and write the line's tag |
| fill_addr | input | 32 | Byte address of the filled word |
| inval_req | input | 1 | Start a whole-cache invalidate sweep |
| busy | output | 1 | Sweep in progress |

## Verification
Directed sequences cover the following cases:
- an empty line;
- a fill with a concurrent lookup of the same word;
- a second word of the same line;
- an eviction by a different tag;
- the first and last bytes inside and just outside the window.

Together these separate line miss, word miss and hit, and confirm that the lookup register sees state from before a same-cycle fill. Random traffic then mixes fills, lookups and out-of-window addresses over a few crowded line indices and all tags, against a bench model of the entries. This exposes faults in field slicing, tag compare and word-mask merging. Invalidate sweeps with fills and repeated requests issued mid-sweep check the busy window length and that busy-time fills are dropped.

// File: rtl/dct_pkg.sv
// Shared definitions for the cache tag and hit unit.
package dct_pkg;
    // Lookup result codes; the code values are part of the port contract.
    typedef enum logic [1:0] {
        RES_NONCACHE  = 2'b00,
        RES_HIT       = 2'b01,
        RES_WORD_MISS = 2'b10,
        RES_LINE_MISS = 2'b11
    } lk_res_e;
endpackage

// File: rtl/dct_window.sv
// Cacheable window decode and address field split.
// Assumes the window is an aligned 2^WIN_BITS region (checked in the top).
// Purely combinational.
module dct_window #(
    parameter logic [31:0] WIN_BASE   = 32'h0010_0000,
    parameter int          WIN_BITS   = 14,
    parameter int          CACHE_BITS = 11,
    parameter int          OFF_BITS   = 4,
    localparam int         TAG_BITS   = WIN_BITS - CACHE_BITS,
    localparam int         IDX_BITS   = CACHE_BITS - OFF_BITS,
    localparam int         WSEL_BITS  = OFF_BITS - 2
) (
    input  logic [31:0]          addr,
    output logic                 in_win,
    output logic [TAG_BITS-1:0]  tag,
    output logic [IDX_BITS-1:0]  idx,
    output logic [WSEL_BITS-1:0] wsel
);
    // Byte lane bits select nothing here.
    logic unused_lane;

    // Window hit: upper address bits must equal the base's upper bits.
    always_comb begin
        in_win = (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
        tag    = addr[WIN_BITS-1:CACHE_BITS];
        idx    = addr[CACHE_BITS-1:OFF_BITS];
        wsel   = addr[OFF_BITS-1:2];
    end

    assign unused_lane = ^addr[1:0];
endmodule

// File: rtl/dct_sweep.sv
// Invalidate sweep sequencer.
// On reset, or on start while idle, it steps an index from 0 to ENTRIES-1, one per
// clock, with busy high throughout. Start is ignored while busy.
module dct_sweep #(
    parameter int ENTRIES  = 128,
    parameter int IDX_BITS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                busy,
    output logic [IDX_BITS-1:0] clr_idx
);
    localparam logic [IDX_BITS-1:0] LAST = IDX_BITS'(ENTRIES - 1);

    // Sweep state: reset forces a fresh sweep from index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b1;
            clr_idx <= '0;
        end else if (busy) begin
            if (clr_idx == LAST) begin
                busy    <= 1'b0;
                clr_idx <= '0;
            end else begin
                clr_idx <= clr_idx + 1'b1;
            end
        end else if (start) begin
            busy    <= 1'b1;
            clr_idx <= '0;
        end
    end

    // R9
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && clr_idx == LAST |=> !busy);
    // R9
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && clr_idx == '0);
    // R9
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && clr_idx != LAST |=> busy && clr_idx == $past(clr_idx) + 1'b1);
endmodule

// File: rtl/dct_tag_store.sv
// Line entry store: tag, line-valid bit and per-word valid bits for each index.
// The sweep clear has priority. The caller only issues fill_go when not sweeping.
// Storage carries no reset: after reset the sweep clears every line-valid bit
// before any lookup can hit.
module dct_tag_store #(
    parameter int ENTRIES    = 128,
    parameter int IDX_BITS   = 7,
    parameter int TAG_BITS   = 3,
    parameter int LINE_WORDS = 4,
    parameter int WSEL_BITS  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_en,
    input  logic [IDX_BITS-1:0]   clr_idx,
    input  logic                  fill_go,
    input  logic [IDX_BITS-1:0]   fill_idx,
    input  logic [TAG_BITS-1:0]   fill_tag,
    input  logic [WSEL_BITS-1:0]  fill_wsel,
    input  logic [IDX_BITS-1:0]   rd_idx,
    output logic                  rd_line_ok,
    output logic [TAG_BITS-1:0]   rd_tag,
    output logic [LINE_WORDS-1:0] rd_words
);
    logic                  lvalid [ENTRIES];
    logic [TAG_BITS-1:0]   tags   [ENTRIES];
    logic [LINE_WORDS-1:0] wvalid [ENTRIES];

    logic                  same_line;
    logic [LINE_WORDS-1:0] word_bit;

    // Fill decision: does the fill extend the current line or replace it?
    always_comb begin
        same_line = lvalid[fill_idx] && (tags[fill_idx] == fill_tag);
        word_bit  = LINE_WORDS'(1) << fill_wsel;
    end

    // Line-valid bits: the sweep clears, a fill sets.
    always_ff @(posedge clk) begin
        if (clr_en)
            lvalid[clr_idx] <= 1'b0;
        else if (fill_go)
            lvalid[fill_idx] <= 1'b1;
    end

    // Tag and word-valid update: merge on same line, restart on a new one.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            if (same_line) begin
                wvalid[fill_idx] <= wvalid[fill_idx] | word_bit;
            end else begin
                tags[fill_idx]   <= fill_tag;
                wvalid[fill_idx] <= word_bit;
            end
        end
    end

    // Read port for the lookup path.
    always_comb begin
        rd_line_ok = lvalid[rd_idx];
        rd_tag     = tags[rd_idx];
        rd_words   = wvalid[rd_idx];
    end

    // R6
    fill_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> lvalid[$past(fill_idx)] && tags[$past(fill_idx)] == $past(fill_tag)
                    && wvalid[$past(fill_idx)][$past(fill_wsel)]);
    // R7
    fill_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go && same_line |=> (wvalid[$past(fill_idx)] & $past(wvalid[fill_idx]))
                                 == $past(wvalid[fill_idx]));
    // R9
    sweep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !lvalid[$past(clr_idx)]);
endmodule

// File: rtl/dct_tag_unit.sv
// Direct-mapped cache tag and hit unit (top).
// Decodes the cacheable window, looks up one line entry per request and
// registers a four-way result. Fills write tags and word-valid bits.
// An invalidate sweep clears one line per clock.
// Assumes a window that is an aligned power of two larger than the cache.
module dct_tag_unit
    import dct_pkg::*;
#(
    parameter logic [31:0] WIN_BASE    = 32'h0010_0000,
    parameter logic [31:0] WIN_HIGH    = 32'h0010_3FFF,
    parameter int          CACHE_BYTES = 2048,
    parameter int          LINE_WORDS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_req,
    input  logic [31:0] lk_addr,
    output logic        lk_valid,
    output logic [1:0]  lk_result,
    output logic        lk_hit,
    input  logic        fill_en,
    input  logic [31:0] fill_addr,
    input  logic        inval_req,
    output logic        busy
);
    localparam logic [32:0] SPAN       = {1'b0, WIN_HIGH} - {1'b0, WIN_BASE} + 33'd1;
    localparam int          WIN_BITS   = $clog2(SPAN);
    localparam int          CACHE_BITS = $clog2(CACHE_BYTES);
    localparam int          OFF_BITS   = $clog2(LINE_WORDS) + 2;
    localparam int          IDX_BITS   = CACHE_BITS - OFF_BITS;
    localparam int          TAG_BITS   = WIN_BITS - CACHE_BITS;
    localparam int          WSEL_BITS  = OFF_BITS - 2;
    localparam int          ENTRIES    = CACHE_BYTES / (LINE_WORDS * 4);

    localparam bit SIZE_OK = CACHE_BYTES >= 64 && CACHE_BYTES <= 65536 &&
                             (CACHE_BYTES & (CACHE_BYTES - 1)) == 0;
    localparam bit LINE_OK = LINE_WORDS == 4 || LINE_WORDS == 8 || LINE_WORDS == 16;
    localparam bit WIN_OK  = WIN_HIGH > WIN_BASE && (SPAN & (SPAN - 33'd1)) == 33'd0 &&
                             ({1'b0, WIN_BASE} & (SPAN - 33'd1)) == 33'd0;
    localparam bit CFG_OK  = SIZE_OK && LINE_OK && WIN_OK && ENTRIES >= 2 &&
                             WIN_BITS > CACHE_BITS;

    // R11
    initial begin
        cfg_chk: assert (CFG_OK)
            else $fatal(1, "dct_tag_unit: unsupported window or cache geometry");
    end

    logic                  lk_in, fl_in, fill_go, line_ok;
    logic [TAG_BITS-1:0]   lk_tag, fl_tag, st_tag;
    logic [IDX_BITS-1:0]   lk_idx, fl_idx, clr_idx;
    logic [WSEL_BITS-1:0]  lk_wsel, fl_wsel;
    logic [LINE_WORDS-1:0] st_words;
    lk_res_e               res_d, res_q;

    dct_window #(.WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
                 .CACHE_BITS(CACHE_BITS), .OFF_BITS(OFF_BITS)) u_lk_win (
        .addr(lk_addr), .in_win(lk_in), .tag(lk_tag), .idx(lk_idx), .wsel(lk_wsel));

    dct_window #(.WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
                 .CACHE_BITS(CACHE_BITS), .OFF_BITS(OFF_BITS)) u_fl_win (
        .addr(fill_addr), .in_win(fl_in), .tag(fl_tag), .idx(fl_idx), .wsel(fl_wsel));

    dct_sweep #(.ENTRIES(ENTRIES), .IDX_BITS(IDX_BITS)) u_sweep (
        .clk(clk), .rst_n(rst_n), .start(inval_req), .busy(busy), .clr_idx(clr_idx));

    // Fills count only inside the window and outside a sweep.
    assign fill_go = fill_en && fl_in && !busy;

    dct_tag_store #(.ENTRIES(ENTRIES), .IDX_BITS(IDX_BITS), .TAG_BITS(TAG_BITS),
                    .LINE_WORDS(LINE_WORDS), .WSEL_BITS(WSEL_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_en(busy), .clr_idx(clr_idx),
        .fill_go(fill_go), .fill_idx(fl_idx), .fill_tag(fl_tag), .fill_wsel(fl_wsel),
        .rd_idx(lk_idx), .rd_line_ok(line_ok), .rd_tag(st_tag), .rd_words(st_words));

    // Classify the lookup from the entry as it stands before this edge.
    always_comb begin
        if (!lk_in)
            res_d = RES_NONCACHE;
        else if (busy || !line_ok || st_tag != lk_tag)
            res_d = RES_LINE_MISS;
        else if (!st_words[lk_wsel])
            res_d = RES_WORD_MISS;
        else
            res_d = RES_HIT;
    end

    // Result register: one clock from request to answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_valid <= 1'b0;
            res_q    <= RES_NONCACHE;
        end else begin
            lk_valid <= lk_req;
            if (lk_req)
                res_q <= res_d;
        end
    end

    assign lk_result = res_q;
    assign lk_hit    = lk_valid && (res_q == RES_HIT);

    // R8
    lk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);
    // R8
    lk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);
    // R1
    noncache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_in |=> lk_result == 2'b00 && !lk_hit);
    // R9
    busy_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_in && busy |=> lk_result == 2'b11);
endmodule

// File: tb/tb_dct_tag_unit.sv
// Self-checking bench for dct_tag_unit with a line-entry reference model.
module tb_dct_tag_unit;
    localparam logic [31:0] BASE  = 32'h0010_0000;
    localparam logic [31:0] HIGH  = 32'h0010_3FFF;
    localparam int          LINES = 128;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_req = 1'b0, fill_en = 1'b0, inval_req = 1'b0;
    logic [31:0] lk_addr = '0, fill_addr = '0;
    logic        lk_valid, lk_hit, busy;
    logic [1:0]  lk_result;

    int checks = 0, errors = 0;

    // Reference model state
    bit       m_lv   [LINES];
    bit [2:0] m_tag  [LINES];
    bit [3:0] m_wv   [LINES];
    bit       m_busy = 1'b1;
    int       m_sidx = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dct_tag_unit dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_valid(lk_valid), .lk_result(lk_result), .lk_hit(lk_hit),
        .fill_en(fill_en), .fill_addr(fill_addr), .inval_req(inval_req), .busy(busy));

    function automatic logic [31:0] mk(int t, int i, int w, int b);
        return BASE | (32'(t) << 11) | (32'(i) << 4) | (32'(w) << 2) | 32'(b);
    endfunction

    function automatic bit inwin(logic [31:0] a);
        return a >= BASE && a <= HIGH;
    endfunction

    // Expected code from the requirements (R1 R3 R4 R5 R9).
    function automatic logic [1:0] exp_res(logic [31:0] a);
        int i = int'(a[10:4]);
        if (!inwin(a)) return 2'b00;
        if (m_busy || !m_lv[i] || m_tag[i] != a[13:11]) return 2'b11;
        if (!m_wv[i][a[3:2]]) return 2'b10;
        return 2'b01;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, check at the next negedge.
    task automatic cyc(bit req, logic [31:0] a, bit fe, logic [31:0] fa, bit inv, string req_tag);
        logic [1:0] e;
        bit b0;
        lk_req = req; lk_addr = a; fill_en = fe; fill_addr = fa; inval_req = inv;
        e = exp_res(a);
        @(posedge clk);
        b0 = m_busy;
        if (!b0 && fe && inwin(fa)) begin   // R6 R7
            int i = int'(fa[10:4]);
            if (m_lv[i] && m_tag[i] == fa[13:11]) m_wv[i] |= 4'(1) << fa[3:2];
            else begin m_tag[i] = fa[13:11]; m_wv[i] = 4'(1) << fa[3:2]; m_lv[i] = 1'b1; end
        end
        if (b0) begin                        // R9 sweep
            m_lv[m_sidx] = 1'b0;
            if (m_sidx == LINES - 1) m_busy = 1'b0; else m_sidx++;
        end else if (inv) begin
            m_busy = 1'b1; m_sidx = 0;
        end
        @(negedge clk);
        chk(lk_valid == req, "R8 lk_valid", 32'(lk_valid), 32'(req));
        chk(busy == m_busy, "R9 busy", 32'(busy), 32'(m_busy));
        if (req) begin
            chk(lk_result == e, req_tag, 32'(lk_result), 32'(e));
            chk(lk_hit == (e == 2'b01), {req_tag, " hit"}, 32'(lk_hit), 32'(e == 2'b01));
        end
    endtask

    function automatic logic [31:0] rnd_addr();
        int r = int'($urandom % 10);
        if (r < 8) return mk(int'($urandom % 8), int'($urandom % 6), int'($urandom % 4),
                             int'($urandom % 4));
        if (r == 8) return HIGH + 32'd1 + ($urandom % 4096);
        return BASE - 32'd1 - ($urandom % 4096);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R10 busy in reset", 32'(busy), 32'd1);
        chk(lk_valid == 1'b0, "R10 lk_valid in reset", 32'(lk_valid), 32'd0);
        rst_n = 1'b1;
        m_busy = 1'b1; m_sidx = 0;
        for (int k = 0; k < LINES; k++) cyc(1'b1, mk(1, k % 6, 0, 0), 1'b0, '0, 1'b0, "R10 sweep miss");
        chk(busy == 1'b0, "R10 sweep length", 32'(busy), 32'd0);

        // Directed corner cases
        cyc(1, mk(2,5,1,0), 0, '0, 0, "R5 empty line");
        cyc(1, mk(2,5,1,0), 1, mk(2,5,1,0), 0, "R8 same-cycle fill unseen");
        cyc(1, mk(2,5,1,3), 0, '0, 0, "R2 R3 byte bits ignored hit");
        cyc(1, mk(2,5,2,0), 0, '0, 0, "R4 word miss");
        cyc(0, '0, 1, mk(2,5,2,1), 0, "R7 merge fill");
        cyc(1, mk(2,5,1,0), 0, '0, 0, "R7 old word kept");
        cyc(1, mk(2,5,2,0), 0, '0, 0, "R7 new word hit");
        cyc(0, '0, 1, mk(5,5,3,0), 0, "R6 evict fill");
        cyc(1, mk(2,5,1,0), 0, '0, 0, "R6 old tag line miss");
        cyc(1, mk(5,5,3,0), 0, '0, 0, "R6 new tag hit");
        cyc(1, mk(5,5,1,0), 0, '0, 0, "R6 other words cleared");
        cyc(1, HIGH, 1, HIGH, 0, "R1 high bound before fill");
        cyc(1, HIGH, 0, '0, 0, "R1 high bound cacheable hit");
        cyc(1, BASE, 0, '0, 0, "R1 base cacheable");
        cyc(1, HIGH + 32'd1, 1, HIGH + 32'd1, 0, "R1 above window");
        cyc(1, BASE - 32'd1, 1, BASE - 32'd1, 0, "R1 below window");
        cyc(1, mk(7,127,0,0), 0, '0, 0, "R1 outside fill ignored");

        // Constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] fa = rnd_addr();
            cyc(($urandom % 3) != 0, rnd_addr(), ($urandom % 2) == 0, fa, 1'b0, "R1 R3 R4 R5 random");
        end

        // R9: invalidate with busy-time fills and repeated requests
        cyc(1, mk(5,5,3,0), 0, '0, 1, "R9 start inval");
        for (int k = 0; k < LINES + 4; k++) begin
            logic [31:0] fa = rnd_addr();
            cyc(1, rnd_addr(), 1'b1, fa, (k % 40) == 3, "R9 during and after sweep");
        end
        for (int k = 0; k < 400; k++) begin
            logic [31:0] fa = rnd_addr();
            cyc(1, rnd_addr(), ($urandom % 2) == 0, fa, k == 200, "R3 R4 R5 R9 post sweep");
        end
        repeat (LINES + 2) cyc(1, mk(int'($urandom % 8), int'($urandom % 6), 0, 0), 0, '0, 0, "R9 drain");
        cyc(1, mk(2,5,1,0), 0, '0, 0, "R9 cleared line miss");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule